// File: doc/BRIEF.md
# Channel Frame Sync Guard with Spindle Lock Flag

This block sits behind an EFM sync-pattern matcher that runs on the recovered channel-bit clock. On every channel bit, marked by a clock enable, it looks at the raw sync-detect input. It decides whether a detected sync belongs to the frame grid it is tracking. When an expected sync fails to arrive, it stands in for that sync by inserting one. Downstream logic receives a registered copy of every raw detection as an active-low pulse. It also receives a "good frame sync" flag, which is high while detections keep landing where the grid predicts, and a status bit that is high while the guard has given up on its window and is searching.

A second, much slower path watches the good-sync flag and drives a spindle lock indicator. It samples that flag once every few ticks of a crystal-derived frame reference, at a few hundred hertz. A single good sample sets the indicator. It clears only after a run of consecutive bad samples. This keeps the spindle servo from dropping lock on short defects.

Top module: `efm_sync_guard`

## Requirements
- R1: `sync_raw_n` is low for exactly one clock after each clock edge on which `bit_en` and `sync_det` are both high. This holds whether or not the detection is accepted. It is high after every other edge.
- R2: After reset, `win_released` is 1, `gfs` is 0, `spindle_lock` is 0 and `sync_raw_n` is 1.
- R3: While `win_released` is 1, any detection (with `bit_en` high) realigns the frame grid: the detection becomes count 0, `win_released` goes to 0 and `gfs` goes to 0.
- R4: While the window is enforced, the count is the number of enabled bits since the last accepted or inserted sync position. A detection at a count from FRAME_LEN-WIN_BITS to FRAME_LEN+WIN_BITS inclusive is accepted: `gfs` becomes 1 and the count restarts at that bit.
- R5: While the window is enforced, a detection at a count below FRAME_LEN-WIN_BITS is ignored. It leaves `gfs`, `win_released` and the timing of the next expected sync unchanged.
- R6: If the count reaches FRAME_LEN+WIN_BITS without an accepted detection, a sync is inserted on that bit and `gfs` becomes 0. The grid keeps its nominal phase: the next expected sync is FRAME_LEN bits after the nominal position.
- R7: After MISS_LIMIT consecutive inserted syncs, `win_released` becomes 1. An accepted detection clears the run.
- R8: On clocks with `bit_en` low, `sync_det` has no effect and the frame count does not advance.
- R9: `gfs` is sampled on every SAMPLE_DIV-th `frame_tick`. A sample that finds `gfs` high sets `spindle_lock` at once.
- R10: `spindle_lock` clears only after LOCK_LOSS consecutive samples that find `gfs` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_en | input | 1 | Channel-bit clock enable |
| sync_det | input | 1 | Raw frame-sync detect, qualified by `bit_en` |
| frame_tick | input | 1 | One-clock crystal frame reference tick |
| sync_raw_n | output | 1 | Active-low monitor pulse per raw detection |
| gfs | output | 1 | Good frame sync flag |
| win_released | output | 1 | High while the window is released (search) |
| spindle_lock | output | 1 | Slowly sampled lock indicator |

## Verification
The bench builds the guard with a 20-bit frame, a window of ±2 bits, a miss limit of 3 and a lock sample every second frame tick. With these values, both window edges, the bit on which a sync is inserted, and a full three-miss release all happen within a few dozen clocks. At this frame length, whole bad-sample runs for the lock flag fit inside one or two frames. This lets directed scenarios hit each edge exactly: the accepted extremes, the first ignored position, the exact clock of the insertion, and the eighth bad sample.

// File: rtl/efm_sync_pkg.sv
package efm_sync_pkg;

  // Outcome of one enabled channel bit as seen by the frame timer.
  typedef enum logic [1:0] {
    EV_NONE    = 2'd0,
    EV_HIT     = 2'd1,
    EV_INSERT  = 2'd2,
    EV_REALIGN = 2'd3
  } frame_ev_e;

endpackage

// File: rtl/efm_frame_timer.sv
module efm_frame_timer
  import efm_sync_pkg::*;
#(
  parameter int FRAME_LEN = 588,
  parameter int WIN_BITS  = 3
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      bit_en,
  input  logic      sync_det,
  input  logic      released,
  output frame_ev_e ev
);

  localparam int LAST_POS = FRAME_LEN + WIN_BITS;
  localparam int CNT_W    = $clog2(LAST_POS + 1);
  localparam logic [CNT_W-1:0] WIN_LO    = CNT_W'(FRAME_LEN - WIN_BITS);
  localparam logic [CNT_W-1:0] WIN_HI    = CNT_W'(LAST_POS);
  localparam logic [CNT_W-1:0] POST_SYNC = CNT_W'(1);
  localparam logic [CNT_W-1:0] POST_INS  = CNT_W'(WIN_BITS + 1);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             in_win;

  assign in_win = (cnt_q >= WIN_LO);

  always_comb begin
    ev    = EV_NONE;
    cnt_d = cnt_q;
    if (bit_en) begin
      if (sync_det && released) begin
        ev    = EV_REALIGN;
        cnt_d = POST_SYNC;
      end else if (sync_det && in_win) begin
        ev    = EV_HIT;
        cnt_d = POST_SYNC;
      end else if (cnt_q == WIN_HI) begin
        // Insert at the late window edge; phase stays on the nominal grid.
        ev    = EV_INSERT;
        cnt_d = POST_INS;
      end else begin
        cnt_d = cnt_q + POST_SYNC;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

endmodule

// File: rtl/efm_sync_protect.sv
module efm_sync_protect
  import efm_sync_pkg::*;
#(
  parameter int MISS_LIMIT = 3
) (
  input  logic      clk,
  input  logic      rst_n,
  input  frame_ev_e ev,
  output logic      released,
  output logic      good_sync
);

  localparam int MISS_W = $clog2(MISS_LIMIT + 1);
  localparam logic [MISS_W-1:0] MISS_MAX = MISS_W'(MISS_LIMIT);
  localparam logic [MISS_W-1:0] MISS_ONE = MISS_W'(1);

  logic [MISS_W-1:0] miss_q, miss_d;
  logic              rel_q, rel_d;
  logic              gfs_q, gfs_d;

  always_comb begin
    miss_d = miss_q;
    rel_d  = rel_q;
    gfs_d  = gfs_q;
    unique case (ev)
      EV_HIT: begin
        miss_d = '0;
        gfs_d  = 1'b1;
      end
      EV_REALIGN: begin
        miss_d = '0;
        rel_d  = 1'b0;
        gfs_d  = 1'b0;
      end
      EV_INSERT: begin
        gfs_d = 1'b0;
        if (!rel_q) begin
          miss_d = miss_q + MISS_ONE;
          if (miss_q + MISS_ONE >= MISS_MAX) begin
            rel_d  = 1'b1;
            miss_d = '0;
          end
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      miss_q <= '0;
      rel_q  <= 1'b1;
      gfs_q  <= 1'b0;
    end else begin
      miss_q <= miss_d;
      rel_q  <= rel_d;
      gfs_q  <= gfs_d;
    end
  end

  assign released  = rel_q;
  assign good_sync = gfs_q;

endmodule

// File: rtl/efm_lock_sampler.sv
module efm_lock_sampler #(
  parameter int SAMPLE_DIV = 16,
  parameter int LOCK_LOSS  = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic frame_tick,
  input  logic good_sync,
  output logic lock
);

  localparam int BAD_W = $clog2(LOCK_LOSS + 1);
  localparam logic [BAD_W-1:0] BAD_MAX = BAD_W'(LOCK_LOSS);
  localparam logic [BAD_W-1:0] BAD_ONE = BAD_W'(1);

  logic sample_en;

  generate
    if (SAMPLE_DIV <= 1) begin : g_direct
      assign sample_en = frame_tick;
    end else begin : g_div
      localparam int DIV_W = $clog2(SAMPLE_DIV);
      localparam logic [DIV_W-1:0] DIV_TOP = DIV_W'(SAMPLE_DIV - 1);
      logic [DIV_W-1:0] div_q, div_d;

      always_comb begin
        div_d = div_q;
        if (frame_tick) div_d = (div_q == DIV_TOP) ? '0 : div_q + DIV_W'(1);
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) div_q <= '0;
        else        div_q <= div_d;
      end

      assign sample_en = frame_tick && (div_q == DIV_TOP);
    end
  endgenerate

  logic [BAD_W-1:0] bad_q, bad_d;
  logic             lock_q, lock_d;

  always_comb begin
    bad_d  = bad_q;
    lock_d = lock_q;
    if (sample_en) begin
      if (good_sync) begin
        bad_d  = '0;
        lock_d = 1'b1;
      end else if (bad_q != BAD_MAX) begin
        bad_d = bad_q + BAD_ONE;
        if (bad_q + BAD_ONE == BAD_MAX) lock_d = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bad_q  <= '0;
      lock_q <= 1'b0;
    end else begin
      bad_q  <= bad_d;
      lock_q <= lock_d;
    end
  end

  assign lock = lock_q;

endmodule

// File: rtl/efm_sync_guard.sv
module efm_sync_guard
  import efm_sync_pkg::*;
#(
  parameter int FRAME_LEN  = 588,
  parameter int WIN_BITS   = 3,
  parameter int MISS_LIMIT = 3,
  parameter int SAMPLE_DIV = 16,
  parameter int LOCK_LOSS  = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bit_en,
  input  logic sync_det,
  input  logic frame_tick,
  output logic sync_raw_n,
  output logic gfs,
  output logic win_released,
  output logic spindle_lock
);

  frame_ev_e ev;
  logic      released;
  logic      good_sync;
  logic      raw_q, raw_d;

  efm_frame_timer #(
    .FRAME_LEN (FRAME_LEN),
    .WIN_BITS  (WIN_BITS)
  ) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .bit_en   (bit_en),
    .sync_det (sync_det),
    .released (released),
    .ev       (ev)
  );

  efm_sync_protect #(
    .MISS_LIMIT (MISS_LIMIT)
  ) u_protect (
    .clk       (clk),
    .rst_n     (rst_n),
    .ev        (ev),
    .released  (released),
    .good_sync (good_sync)
  );

  efm_lock_sampler #(
    .SAMPLE_DIV (SAMPLE_DIV),
    .LOCK_LOSS  (LOCK_LOSS)
  ) u_lock (
    .clk        (clk),
    .rst_n      (rst_n),
    .frame_tick (frame_tick),
    .good_sync  (good_sync),
    .lock       (spindle_lock)
  );

  assign raw_d = ~(bit_en & sync_det);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) raw_q <= 1'b1;
    else        raw_q <= raw_d;
  end

  assign sync_raw_n   = raw_q;
  assign gfs          = good_sync;
  assign win_released = released;

endmodule

// File: rtl/efm_sync_guard_chk.sv
module efm_sync_guard_chk (
  input logic clk,
  input logic rst_n,
  input logic bit_en,
  input logic sync_det,
  input logic frame_tick,
  input logic sync_raw_n,
  input logic gfs,
  input logic win_released,
  input logic spindle_lock
);

  AST_RAW_IDLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    !(bit_en && sync_det) |=> sync_raw_n); // R1

  AST_SEARCH_REALIGN: assert property (@(posedge clk) disable iff (!rst_n)
    (win_released && bit_en && sync_det) |=> (!win_released && !gfs)); // R3

  AST_GFS_NEEDS_DETECT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gfs) |-> $past(bit_en && sync_det)); // R4

  AST_IDLE_BIT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_en |=> ($stable(gfs) && $stable(win_released))); // R8

  AST_LOCK_RISE_ON_GOOD: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(spindle_lock) |-> $past(gfs && frame_tick)); // R9

  AST_LOCK_FALL_ON_BAD: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(spindle_lock) |-> $past(!gfs && frame_tick)); // R10

endmodule

bind efm_sync_guard efm_sync_guard_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .bit_en       (bit_en),
  .sync_det     (sync_det),
  .frame_tick   (frame_tick),
  .sync_raw_n   (sync_raw_n),
  .gfs          (gfs),
  .win_released (win_released),
  .spindle_lock (spindle_lock)
);

// File: tb/efm_sync_guard_bench.sv
`timescale 1ns/1ps
module efm_sync_guard_bench;

  localparam int FRAME_LEN  = 20;
  localparam int WIN_BITS   = 2;
  localparam int MISS_LIMIT = 3;
  localparam int SAMPLE_DIV = 2;
  localparam int LOCK_LOSS  = 8;

  logic clk;
  logic rst_n;
  logic bit_en;
  logic sync_det;
  logic frame_tick;
  logic sync_raw_n;
  logic gfs;
  logic win_released;
  logic spindle_lock;

  int n_checks;
  int n_fails;
  int n_cycles;
  bit done;

  efm_sync_guard #(
    .FRAME_LEN  (FRAME_LEN),
    .WIN_BITS   (WIN_BITS),
    .MISS_LIMIT (MISS_LIMIT),
    .SAMPLE_DIV (SAMPLE_DIV),
    .LOCK_LOSS  (LOCK_LOSS)
  ) u_efm_sync_guard (
    .clk          (clk),
    .rst_n        (rst_n),
    .bit_en       (bit_en),
    .sync_det     (sync_det),
    .frame_tick   (frame_tick),
    .sync_raw_n   (sync_raw_n),
    .gfs          (gfs),
    .win_released (win_released),
    .spindle_lock (spindle_lock)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    n_cycles <= n_cycles + 1;
    if (n_cycles > 20000) begin
      n_fails = n_fails + 1;
      $display("FAIL watchdog: run did not finish, actual hung expected done");
      finish_run();
    end
  end

  task automatic expect_bit(input string req, input string sig, input logic act, input logic exp);
    n_checks = n_checks + 1;
    if (act !== exp) begin
      n_fails = n_fails + 1;
      $display("FAIL %s %s: actual %b expected %b", req, sig, act, exp);
    end
  endtask

  // Drive one clock's worth of inputs, applied away from the active edge.
  task automatic step(input logic s, input logic t, input logic e);
    @(negedge clk);
    sync_det   = s;
    frame_tick = t;
    bit_en     = e;
  endtask

  task automatic zeros(input int n, input logic t);
    for (int i = 0; i < n; i++) step(1'b0, t, 1'b1);
  endtask

  // Sync detection on the g-th enabled bit from now.
  task automatic frame(input int g);
    zeros(g - 1, 1'b0);
    step(1'b1, 1'b0, 1'b1);
  endtask

  task automatic observe();
    @(posedge clk);
    #2;
  endtask

  task automatic t_reset();
    rst_n = 1'b0; bit_en = 1'b0; sync_det = 1'b0; frame_tick = 1'b0;
    repeat (3) @(posedge clk);
    #2;
    expect_bit("R2", "win_released", win_released, 1'b1);
    expect_bit("R2", "gfs", gfs, 1'b0);
    expect_bit("R2", "spindle_lock", spindle_lock, 1'b0);
    expect_bit("R2", "sync_raw_n", sync_raw_n, 1'b1);
    @(negedge clk);
    rst_n = 1'b1;
    observe();
    expect_bit("R2", "win_released after release", win_released, 1'b1);
  endtask

  task automatic t_acquire();
    frame(5);
    observe();
    expect_bit("R1", "sync_raw_n on detect", sync_raw_n, 1'b0);
    expect_bit("R3", "win_released after realign", win_released, 1'b0);
    expect_bit("R3", "gfs after realign", gfs, 1'b0);
    frame(FRAME_LEN);
    observe();
    expect_bit("R4", "gfs on-time sync", gfs, 1'b1);
  endtask

  task automatic t_window();
    zeros(FRAME_LEN + WIN_BITS, 1'b0);
    observe();
    expect_bit("R6", "gfs after insertion", gfs, 1'b0);
    // Nominal sync was 2 bits before the insertion: 16 more bits hit the early edge.
    frame(FRAME_LEN - WIN_BITS - WIN_BITS);
    observe();
    expect_bit("R4", "gfs early window edge", gfs, 1'b1);
    frame(FRAME_LEN + WIN_BITS);
    observe();
    expect_bit("R4", "gfs late window edge", gfs, 1'b1);
    frame(FRAME_LEN - WIN_BITS - 1);
    observe();
    expect_bit("R5", "gfs after early sync", gfs, 1'b1);
    expect_bit("R1", "sync_raw_n on ignored detect", sync_raw_n, 1'b0);
    expect_bit("R5", "win_released after early sync", win_released, 1'b0);
    step(1'b0, 1'b0, 1'b1);
    observe();
    expect_bit("R1", "sync_raw_n back high", sync_raw_n, 1'b1);
    zeros(3, 1'b0);
    observe();
    expect_bit("R5", "gfs one bit before insertion", gfs, 1'b1);
    step(1'b0, 1'b0, 1'b1);
    observe();
    expect_bit("R6", "gfs insertion kept old phase", gfs, 1'b0);
  endtask

  task automatic t_release();
    zeros(2 * FRAME_LEN - 1, 1'b0);
    observe();
    expect_bit("R7", "win_released before third miss", win_released, 1'b0);
    step(1'b0, 1'b0, 1'b1);
    observe();
    expect_bit("R7", "win_released on third miss", win_released, 1'b1);
    frame(7);
    observe();
    expect_bit("R3", "win_released after search hit", win_released, 1'b0);
    expect_bit("R3", "gfs after search hit", gfs, 1'b0);
    frame(FRAME_LEN);
    observe();
    expect_bit("R4", "gfs after reacquire", gfs, 1'b1);
  endtask

  task automatic t_lock();
    step(1'b0, 1'b1, 1'b1);
    observe();
    expect_bit("R9", "spindle_lock before sample", spindle_lock, 1'b0);
    step(1'b0, 1'b1, 1'b1);
    observe();
    expect_bit("R9", "spindle_lock on one good sample", spindle_lock, 1'b1);
    zeros(FRAME_LEN, 1'b0);
    observe();
    expect_bit("R6", "gfs dropped for lock test", gfs, 1'b0);
    zeros(2 * (LOCK_LOSS - 1), 1'b1);
    observe();
    expect_bit("R10", "spindle_lock after seven bad", spindle_lock, 1'b1);
    zeros(2, 1'b1);
    observe();
    expect_bit("R10", "spindle_lock after eighth bad", spindle_lock, 1'b0);
    step(1'b1, 1'b0, 1'b1);
    observe();
    expect_bit("R4", "gfs back in window", gfs, 1'b1);
    zeros(2, 1'b1);
    observe();
    expect_bit("R9", "spindle_lock regained", spindle_lock, 1'b1);
  endtask

  task automatic t_enable();
    for (int i = 0; i < 10; i++) step(1'b1, 1'b0, 1'b0);
    observe();
    expect_bit("R8", "sync_raw_n with bit_en low", sync_raw_n, 1'b1);
    expect_bit("R8", "gfs with bit_en low", gfs, 1'b1);
    zeros(FRAME_LEN - 1, 1'b0);
    observe();
    expect_bit("R8", "gfs count frozen while idle", gfs, 1'b1);
    step(1'b0, 1'b0, 1'b1);
    observe();
    expect_bit("R8", "gfs insertion after frozen gap", gfs, 1'b0);
  endtask

  initial begin
    n_checks = 0;
    n_fails  = 0;
    n_cycles = 0;
    done     = 1'b0;
    t_reset();
    t_acquire();
    t_window();
    t_release();
    t_lock();
    t_enable();
    finish_run();
  end

endmodule